// File: doc/BRIEF.md
# DS3 Frame-Slave Serial Payload Input

This block takes the serial payload stream for a DS3 transmitter when the transmit side runs from its own input clock (nominally 44.736 MHz) and frame timing is set by the system. Every rising clock edge registers one bit from the serial input. A bit-position counter tracks where the current bit falls inside a 4760-bit M-frame. The M-frame is seven subframes of eight 85-bit blocks, and the first bit of every block is an overhead slot.

The block reports that position back to the equipment that feeds it. An overhead flag marks the bit periods in which the equipment must not present payload. An end-of-frame flag marks the final bit of each full frame. Captured bits leave on a bit/valid pair, and valid is set only for payload slots. A rising edge on the frame-reference input restarts the counter, so the system side owns frame alignment. With no reference edge, the counter wraps on its own and keeps the last alignment.

Top module: `ds3_slave_payload_in`

## Requirements
- R1: A bit is captured when `pay_vld` is high. In that case `pay_bit` equals the value `ser_in` had at the previous rising clock edge.
- R2: `oh_ind` is high exactly when the current bit position is a multiple of 85, which is the first bit of each 85-bit block. This gives 56 overhead positions per 4760-bit frame.
- R3: `eof` is high for one cycle, exactly while the position is 4759, the final bit of the frame.
- R4: With no reference edge, the position advances by one each cycle and wraps from 4759 to 0. End-of-frame flags therefore recur every 4760 cycles.
- R5: Suppose a clock edge samples `fref_in` high and the previous edge sampled it low. Then the position is 0 in the following cycle and `oh_ind` is high. The next `eof` comes 4759 cycles later.
- R6: A restart in the middle of a frame produces no `eof` for the truncated frame.
- R7: Holding `fref_in` high, or a falling edge on it, does not disturb the frame position.
- R8: While `rst` is high, `oh_ind`, `eof` and `pay_vld` are low and the position clears to 0. The first cycle after reset keeps the outputs low and discards its bit. A `fref_in` held high through reset is not treated as an edge, so the first `eof` follows 4759 cycles after release.
- R9: A bit taken during an overhead slot is never marked valid: `pay_vld` is low in the cycle after `oh_ind` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit timing clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial payload data from the system side |
| fref_in | input | 1 | Frame reference; a rising edge restarts the frame |
| oh_ind | output | 1 | Current bit period is an overhead slot |
| eof | output | 1 | Current bit period is the last bit of the frame |
| pay_bit | output | 1 | Most recently captured bit |
| pay_vld | output | 1 | `pay_bit` holds a payload bit |

## Verification
The hardest cases are a reference edge that lands mid-frame and a reference held high through reset. Both show up only as the absence of an end-of-frame flag at the time the old alignment would have produced one. To reach them, the stimulus first runs two full frames to fix the free-running alignment. It then raises the reference 1000 bits into a frame and keeps it high past the point where the old frame would have ended. Finally it holds the reference high across a reset. In each case the bench counts cycles to the first end-of-frame flag that follows.

// File: rtl/ds3_pin_pkg.sv
package ds3_pin_pkg;
    localparam int unsigned DEF_BLOCK_BITS   = 85;
    localparam int unsigned DEF_BLOCKS_PER_SF = 8;
    localparam int unsigned DEF_SUBFRAMES    = 7;

    function automatic int unsigned frame_len(input int unsigned blk_bits,
                                              input int unsigned blks,
                                              input int unsigned sfs);
        return blk_bits * blks * sfs;
    endfunction
endpackage

// File: rtl/ds3_ref_edge.sv
module ds3_ref_edge (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // sample the level even in reset so a held-high level is not an edge
        st_d.prev = ref_in;
        rise_o    = !rst && ref_in && !st_q.prev;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/ds3_frame_pos.sv
module ds3_frame_pos #(
    parameter int unsigned BLOCK_BITS    = ds3_pin_pkg::DEF_BLOCK_BITS,
    parameter int unsigned BLOCKS_PER_SF = ds3_pin_pkg::DEF_BLOCKS_PER_SF,
    parameter int unsigned SUBFRAMES     = ds3_pin_pkg::DEF_SUBFRAMES
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic oh_o,
    output logic last_o,
    output logic payload_slot_o
);
    localparam int unsigned FRAME_BITS = ds3_pin_pkg::frame_len(BLOCK_BITS, BLOCKS_PER_SF, SUBFRAMES);
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
    localparam int unsigned BLK_W      = $clog2(BLOCK_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCK_BITS - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [BLK_W-1:0] blk;
    } pos_st_t;

    pos_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = 1'b1;
        if (rst) begin
            st_d = '0;
        end else if (restart) begin
            st_d.cnt = '0;
            st_d.blk = '0;
        end else begin
            st_d.cnt = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + 1'b1;
            st_d.blk = (st_q.cnt == CNT_LAST || st_q.blk == BLK_LAST) ? '0 : st_q.blk + 1'b1;
        end
        oh_o           = st_q.run && (st_q.blk == '0);
        last_o         = st_q.run && (st_q.cnt == CNT_LAST);
        payload_slot_o = st_q.run && (st_q.blk != '0);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/ds3_payload_cap.sv
module ds3_payload_cap (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic take,
    output logic bit_o,
    output logic vld_o
);
    typedef struct packed {
        logic data;
        logic vld;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d.data = ser_in;
        st_d.vld  = take;
        if (rst) begin
            st_d = '0;
        end
        bit_o = st_q.data;
        vld_o = st_q.vld;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/ds3_slave_payload_in.sv
module ds3_slave_payload_in #(
    parameter int unsigned BLOCK_BITS    = ds3_pin_pkg::DEF_BLOCK_BITS,
    parameter int unsigned BLOCKS_PER_SF = ds3_pin_pkg::DEF_BLOCKS_PER_SF,
    parameter int unsigned SUBFRAMES     = ds3_pin_pkg::DEF_SUBFRAMES
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic fref_in,
    output logic oh_ind,
    output logic eof,
    output logic pay_bit,
    output logic pay_vld
);
    logic ref_rise;
    logic slot_payload;

    ds3_ref_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .ref_in (fref_in),
        .rise_o (ref_rise)
    );

    ds3_frame_pos #(
        .BLOCK_BITS    (BLOCK_BITS),
        .BLOCKS_PER_SF (BLOCKS_PER_SF),
        .SUBFRAMES     (SUBFRAMES)
    ) u_pos (
        .clk            (clk),
        .rst            (rst),
        .restart        (ref_rise),
        .oh_o           (oh_ind),
        .last_o         (eof),
        .payload_slot_o (slot_payload)
    );

    ds3_payload_cap u_cap (
        .clk    (clk),
        .rst    (rst),
        .ser_in (ser_in),
        .take   (slot_payload),
        .bit_o  (pay_bit),
        .vld_o  (pay_vld)
    );
endmodule

// File: rtl/ds3_slave_payload_in_chk.sv
module ds3_slave_payload_in_chk (
    input logic clk,
    input logic rst,
    input logic ser_in,
    input logic fref_in,
    input logic oh_ind,
    input logic eof,
    input logic pay_bit,
    input logic pay_vld
);
    // R3
    eof_single_chk: assert property (@(posedge clk) disable iff (rst) eof |=> !eof);

    // R2
    eof_not_overhead_chk: assert property (@(posedge clk) disable iff (rst) eof |-> !oh_ind);

    // R4
    wrap_to_block_start_chk: assert property (@(posedge clk) disable iff (rst) eof |=> oh_ind);

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (fref_in && !$past(fref_in) && !$past(rst)) |=> oh_ind);

    // R9
    overhead_not_valid_chk: assert property (@(posedge clk) disable iff (rst) oh_ind |=> !pay_vld);

    // R1
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        pay_vld |-> (pay_bit == $past(ser_in)));

    // R8
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!oh_ind && !eof && !pay_vld));
endmodule

bind ds3_slave_payload_in ds3_slave_payload_in_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ser_in  (ser_in),
    .fref_in (fref_in),
    .oh_ind  (oh_ind),
    .eof     (eof),
    .pay_bit (pay_bit),
    .pay_vld (pay_vld)
);

// File: tb/ds3_slave_payload_in_test.sv
module ds3_slave_payload_in_test;
    localparam int FRAME = 4760;
    localparam int BLK   = 85;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic fref_in = 1'b0;
    logic oh_ind, eof, pay_bit, pay_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected-state model built from the requirements
    int   m_pos = 0;
    bit   m_run = 1'b0;
    bit   m_prev = 1'b0;
    bit   m_pv = 1'b0;
    logic m_pb = 1'b0;
    int   lfsr = 32'h1ACE5;

    always #10 clk = ~clk;

    ds3_slave_payload_in uut (
        .clk     (clk),
        .rst     (rst),
        .ser_in  (ser_in),
        .fref_in (fref_in),
        .oh_ind  (oh_ind),
        .eof     (eof),
        .pay_bit (pay_bit),
        .pay_vld (pay_vld)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[0];
    endfunction

    task automatic step(input logic s, input logic r);
        ser_in  = s;
        fref_in = r;
        @(posedge clk);
        #5;
        if (rst) begin
            m_run = 1'b0; m_pos = 0; m_prev = r; m_pv = 1'b0;
        end else begin
            m_pv = m_run && (m_pos % BLK != 0);
            m_pb = s;
            if (r && !m_prev) m_pos = 0;
            else m_pos = (m_pos == FRAME - 1) ? 0 : m_pos + 1;
            m_prev = r;
            m_run = 1'b1;
        end
        check(oh_ind == (m_run && (m_pos % BLK == 0)), "R2 oh_ind", int'(oh_ind), int'(m_run && (m_pos % BLK == 0)));
        check(eof == (m_run && m_pos == FRAME - 1), "R3 eof", int'(eof), int'(m_run && m_pos == FRAME - 1));
        check(pay_vld == m_pv, "R9 pay_vld", int'(pay_vld), int'(m_pv));
        if (m_pv) check(pay_bit == m_pb, "R1 pay_bit", int'(pay_bit), int'(m_pb));
    endtask

    task automatic test_reset();
        rst = 1'b1;
        for (int i = 0; i < 4; i++) step(next_bit(), 1'b0);
        check(!oh_ind && !eof && !pay_vld, "R8 outputs low in reset", int'({oh_ind, eof, pay_vld}), 0);
        rst = 1'b0;
        step(1'b1, 1'b0);
        check(!pay_vld && !oh_ind, "R8 first bit after reset discarded", int'({oh_ind, pay_vld}), 0);
    endtask

    task automatic test_free_run();
        int first_eof = -1;
        int second_eof = -1;
        int oh_cnt = 0;
        // one step already taken after release
        for (int j = 2; j <= 2 * FRAME; j++) begin
            step(next_bit(), 1'b0);
            if (j >= 1 && j <= FRAME && oh_ind) oh_cnt++;
            if (eof) begin
                if (first_eof < 0) first_eof = j;
                else if (second_eof < 0) second_eof = j;
            end
        end
        check(oh_cnt == 56, "R2 overhead slots per frame", oh_cnt, 56);
        check(first_eof == FRAME - 1, "R3 first eof position", first_eof, FRAME - 1);
        check(second_eof == 2 * FRAME - 1, "R4 wrap period", second_eof, 2 * FRAME - 1);
    endtask

    task automatic test_mid_restart();
        int eof_at = -1;
        for (int j = 0; j < 1000; j++) step(next_bit(), 1'b0);
        step(next_bit(), 1'b1);
        check(oh_ind == 1'b1, "R5 position 0 after edge", int'(oh_ind), 1);
        // keep the reference high past the old frame end, then drop it
        for (int k = 1; k <= FRAME + 5; k++) begin
            step(next_bit(), (k < 4000) ? 1'b1 : 1'b0);
            if (eof && eof_at < 0) eof_at = k;
        end
        check(eof_at == FRAME - 1, "R6 no eof for truncated frame", eof_at, FRAME - 1);
        check(eof_at == FRAME - 1, "R7 held-high and falling reference ignored", eof_at, FRAME - 1);
    endtask

    task automatic test_ref_high_reset();
        int eof_at = -1;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(next_bit(), 1'b1);
        rst = 1'b0;
        for (int j = 1; j <= FRAME; j++) begin
            step(next_bit(), 1'b1);
            if (eof && eof_at < 0) eof_at = j;
        end
        check(eof_at == FRAME - 1, "R8 reference high through reset is no edge", eof_at, FRAME - 1);
        step(next_bit(), 1'b0);
        step(next_bit(), 1'b1);
        check(oh_ind == 1'b1, "R5 edge after low period restarts", int'(oh_ind), 1);
    endtask

    initial begin
        test_reset();
        test_free_run();
        test_mid_restart();
        test_ref_high_reset();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule